// File: doc/BRIEF.md
# Synchronous Loadable Binary Counter

A binary counter built from cascaded stages of W bits each (four by default), two stages giving an 8-bit count. Every change happens on the rising clock edge. A clear input forces the count to zero. A load input copies a parallel value into the count. Otherwise the count advances by one when two enables are both high. Only the second enable, the carry enable, takes part in the carry-out. The carry-out goes high when that enable is high and the count is all ones. Between stages, each stage's carry-out drives the carry enable of the stage above it.

A build-time mode can feed the carry-out or a decoded count back into the counter so that it runs a shortened sequence. In reload mode the carry-out starts a load of a constant, so the counter runs from the constant up to the top value and repeats. In truncate mode, reaching a chosen count forces a clear on the next edge, so the counter runs from zero up to that value. The block has no reset input. The count is undefined until the first clear.

Top module: `modcnt_top`

## Requirements
- R1: When `clr_i` is high at a rising edge, the count becomes 0 on that edge, whatever `ld_i`, the enables and the load value are.
- R2: When `ld_i` is high and `clr_i` is low at a rising edge, the count becomes `ld_val_i`, whatever the enables are. In truncate mode this holds only when the count is not at the truncation value (see R8).
- R3: When neither clear nor load acts, the count rises by one (modulo 2^N) only if `en_a_i` and `en_c_i` are both high. Otherwise it holds its value.
- R4: `carry_o` is high in exactly those cycles where `en_c_i` is high and the count is all ones. `en_a_i` has no effect on it. It follows its inputs combinationally within the same cycle.
- R5: With both enables high and no clear or load, the default 8-bit counter goes from 255 to 0, so it divides the clock by 256.
- R6: An upper stage advances only on an edge where every lower stage is at 15 and counting is enabled. With the 8-bit counter, 0x0F followed by a count edge gives 0x10.
- R7: In reload mode (one 4-bit stage, reload constant 5), a high carry-out at an edge with no clear or load loads 5. This happens even when `en_a_i` is low. With both enables held high the sequence is 5, 6, ..., 15, 5, ...
- R8: In truncate mode (one 4-bit stage, truncation value 10), a count of 10 at an edge gives 0 on that edge, whatever load and the enables are. With both enables held high the sequence is 0 through 10 and then 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_i | input | 1 | Synchronous clear, active high, highest priority |
| ld_i | input | 1 | Synchronous parallel load, active high |
| en_a_i | input | 1 | Count enable that does not affect the carry-out |
| en_c_i | input | 1 | Count enable that also gates the carry-out |
| ld_val_i | input | STAGES*W (8) | Value copied into the count on a load |
| cnt_o | output | STAGES*W (8) | Current count |
| carry_o | output | 1 | Carry-out of the top stage, combinational |

## Verification
Several controls can act on the same edge, and the priority order among them is what gets tested. The first directed case drives clear together with load and both enables. A later case loads while both enables are high. In reload mode, the carry feedback can meet an external load on the same edge. In truncate mode, the truncation value can meet a load request on the same edge. Random stimulus sets clear, load and the enables independently, so these collisions recur many times. Each result is compared with a bench model that applies clear, then truncation, then load, then reload, then count. Each compare is tagged with the control that should have won.

// File: rtl/modcnt_pkg.sv
package modcnt_pkg;
   // Feedback variant chosen at build time
   typedef enum logic [1:0] {
      FB_NONE   = 2'd0,   // plain counter, no feedback
      FB_RELOAD = 2'd1,   // carry-out requests a load of a constant
      FB_TRUNC  = 2'd2    // a decoded count requests a clear
   } fb_mode_e;
endpackage

// File: rtl/modcnt_stage.sv
module modcnt_stage #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         ld,
   input  logic         en_a,
   input  logic         en_c,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         co
);
   // priority: clear, then load, then count
   always_ff @(posedge clk) begin
      if (clr)
         q <= '0;
      else if (ld)
         q <= d;
      else if (en_a && en_c)
         q <= q + 1'b1;
   end

   // carry is gated by en_c only, so stages can chain
   assign co = en_c && (&q);
endmodule

// File: rtl/modcnt_chain.sv
module modcnt_chain #(
   parameter int STAGES = 2,
   parameter int W      = 4
) (
   input  logic                  clk,
   input  logic                  clr,
   input  logic                  ld,
   input  logic                  en_a,
   input  logic                  en_c,
   input  logic [STAGES*W-1:0]   d,
   output logic [STAGES*W-1:0]   q,
   output logic                  co
);
   logic [STAGES:0] cy;

   assign cy[0] = en_c;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      modcnt_stage #(.W(W)) u_st (
         .clk  (clk),
         .clr  (clr),
         .ld   (ld),
         .en_a (en_a),
         .en_c (cy[k]),
         .d    (d[k*W +: W]),
         .q    (q[k*W +: W]),
         .co   (cy[k+1])
      );
   end

   assign co = cy[STAGES];
endmodule

// File: rtl/modcnt_fb.sv
module modcnt_fb #(
   parameter int                  N          = 8,
   parameter modcnt_pkg::fb_mode_e MODE      = modcnt_pkg::FB_NONE,
   parameter int                  RELOAD_VAL = 0,
   parameter int                  CLR_AT     = 0
) (
   input  logic [N-1:0] cnt_i,
   input  logic         carry_i,
   input  logic         clr_i,
   input  logic         ld_i,
   input  logic [N-1:0] ld_val_i,
   output logic         clr_o,
   output logic         ld_o,
   output logic [N-1:0] val_o
);
   localparam logic [N-1:0] RVAL = RELOAD_VAL[N-1:0];
   localparam logic [N-1:0] CVAL = CLR_AT[N-1:0];

   // not every variant looks at both feedback sources
   logic unused_fb;
   assign unused_fb = &{1'b0, cnt_i, carry_i};

   if (MODE == modcnt_pkg::FB_RELOAD) begin : g_reload
      // an external load keeps its own value; otherwise the constant
      assign clr_o = clr_i;
      assign ld_o  = ld_i | carry_i;
      assign val_o = ld_i ? ld_val_i : RVAL;
   end else if (MODE == modcnt_pkg::FB_TRUNC) begin : g_trunc
      // decoded top count acts as a clear and so beats load
      assign clr_o = clr_i | (cnt_i == CVAL);
      assign ld_o  = ld_i;
      assign val_o = ld_val_i;
   end else begin : g_none
      assign clr_o = clr_i;
      assign ld_o  = ld_i;
      assign val_o = ld_val_i;
   end
endmodule

// File: rtl/modcnt_top.sv
module modcnt_top #(
   parameter int                   STAGES     = 2,
   parameter int                   W          = 4,
   parameter modcnt_pkg::fb_mode_e MODE       = modcnt_pkg::FB_NONE,
   parameter int                   RELOAD_VAL = 0,
   parameter int                   CLR_AT     = 0
) (
   input  logic                  clk,
   input  logic                  clr_i,
   input  logic                  ld_i,
   input  logic                  en_a_i,
   input  logic                  en_c_i,
   input  logic [STAGES*W-1:0]   ld_val_i,
   output logic [STAGES*W-1:0]   cnt_o,
   output logic                  carry_o
);
   localparam int N = STAGES * W;

   // build-time parameter checks
   if (W < 1 || STAGES < 1) begin : g_bad_size
      $error("modcnt_top: W and STAGES must be at least 1");
   end
   if (N > 31) begin : g_bad_width
      $error("modcnt_top: total width must stay below 32 bits");
   end
   if (RELOAD_VAL < 0 || RELOAD_VAL >= (1 << N)) begin : g_bad_reload
      $error("modcnt_top: RELOAD_VAL does not fit the count width");
   end
   if (CLR_AT < 0 || CLR_AT >= (1 << N)) begin : g_bad_clr
      $error("modcnt_top: CLR_AT does not fit the count width");
   end

   logic         clr_eff;
   logic         ld_eff;
   logic [N-1:0] val_eff;

   modcnt_fb #(
      .N          (N),
      .MODE       (MODE),
      .RELOAD_VAL (RELOAD_VAL),
      .CLR_AT     (CLR_AT)
   ) u_fb (
      .cnt_i    (cnt_o),
      .carry_i  (carry_o),
      .clr_i    (clr_i),
      .ld_i     (ld_i),
      .ld_val_i (ld_val_i),
      .clr_o    (clr_eff),
      .ld_o     (ld_eff),
      .val_o    (val_eff)
   );

   modcnt_chain #(
      .STAGES (STAGES),
      .W      (W)
   ) u_chain (
      .clk  (clk),
      .clr  (clr_eff),
      .ld   (ld_eff),
      .en_a (en_a_i),
      .en_c (en_c_i),
      .d    (val_eff),
      .q    (cnt_o),
      .co   (carry_o)
   );
endmodule

// File: rtl/modcnt_chk.sv
module modcnt_chk #(
   parameter int                   STAGES     = 2,
   parameter int                   W          = 4,
   parameter modcnt_pkg::fb_mode_e MODE       = modcnt_pkg::FB_NONE,
   parameter int                   RELOAD_VAL = 0,
   parameter int                   CLR_AT     = 0
) (
   input logic                  clk,
   input logic                  clr_i,
   input logic                  ld_i,
   input logic                  en_a_i,
   input logic                  en_c_i,
   input logic [STAGES*W-1:0]   ld_val_i,
   input logic [STAGES*W-1:0]   cnt_o,
   input logic                  carry_o
);
   localparam int N = STAGES * W;
   localparam logic [N-1:0] RVAL = RELOAD_VAL[N-1:0];
   localparam logic [N-1:0] CVAL = CLR_AT[N-1:0];

   // count is undefined until the first clear has been clocked
   logic armed = 1'b0;
   always_ff @(posedge clk)
      if (clr_i) armed <= 1'b1;

   p_clear_r1: assert property (@(posedge clk) disable iff (!armed)
      clr_i |=> (cnt_o == '0));

   p_carry_set_r4: assert property (@(posedge clk) disable iff (!armed)
      (en_c_i && (&cnt_o)) |-> carry_o);

   p_carry_clr_r4: assert property (@(posedge clk) disable iff (!armed)
      carry_o |-> (en_c_i && (&cnt_o)));

   if (MODE == modcnt_pkg::FB_NONE) begin : g_none
      p_load_r2: assert property (@(posedge clk) disable iff (!armed)
         (!clr_i && ld_i) |=> (cnt_o == $past(ld_val_i)));
      p_inc_r3: assert property (@(posedge clk) disable iff (!armed)
         (!clr_i && !ld_i && en_a_i && en_c_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
      p_hold_r3: assert property (@(posedge clk) disable iff (!armed)
         (!clr_i && !ld_i && !(en_a_i && en_c_i)) |=> $stable(cnt_o));
      if (STAGES > 1) begin : g_casc
         p_upper_r6: assert property (@(posedge clk) disable iff (!armed)
            (!clr_i && !ld_i && !(&cnt_o[W-1:0])) |=> $stable(cnt_o[N-1:W]));
      end
   end else if (MODE == modcnt_pkg::FB_RELOAD) begin : g_reload
      p_reload_r7: assert property (@(posedge clk) disable iff (!armed)
         (!clr_i && !ld_i && carry_o) |=> (cnt_o == RVAL));
   end else begin : g_trunc
      p_trunc_r8: assert property (@(posedge clk) disable iff (!armed)
         (cnt_o == CVAL) |=> (cnt_o == '0));
   end
endmodule

bind modcnt_top modcnt_chk #(
   .STAGES     (STAGES),
   .W          (W),
   .MODE       (MODE),
   .RELOAD_VAL (RELOAD_VAL),
   .CLR_AT     (CLR_AT)
) u_chk (
   .clk      (clk),
   .clr_i    (clr_i),
   .ld_i     (ld_i),
   .en_a_i   (en_a_i),
   .en_c_i   (en_c_i),
   .ld_val_i (ld_val_i),
   .cnt_o    (cnt_o),
   .carry_o  (carry_o)
);

// File: tb/sim_modcnt_top.sv
`timescale 1ns/1ps
module sim_modcnt_top;
   import modcnt_pkg::*;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz

   logic       clr = 1'b1, ld = 1'b0, ea = 1'b0, ec = 1'b0;
   logic [7:0] v = 8'h00;
   logic [7:0] q0;
   logic [3:0] q1, q2;
   logic       c0, c1, c2;

   modcnt_top #(.STAGES(2), .W(4), .MODE(FB_NONE)) u0 (
      .clk(clk), .clr_i(clr), .ld_i(ld), .en_a_i(ea), .en_c_i(ec),
      .ld_val_i(v), .cnt_o(q0), .carry_o(c0));
   modcnt_top #(.STAGES(1), .W(4), .MODE(FB_RELOAD), .RELOAD_VAL(5)) u1 (
      .clk(clk), .clr_i(clr), .ld_i(ld), .en_a_i(ea), .en_c_i(ec),
      .ld_val_i(v[3:0]), .cnt_o(q1), .carry_o(c1));
   modcnt_top #(.STAGES(1), .W(4), .MODE(FB_TRUNC), .CLR_AT(10)) u2 (
      .clk(clk), .clr_i(clr), .ld_i(ld), .en_a_i(ea), .en_c_i(ec),
      .ld_val_i(v[3:0]), .cnt_o(q2), .carry_o(c2));

   int    nchk = 0, nfail = 0;
   bit    valid = 1'b0, done = 1'b0;
   int    m0 = 0, m1 = 0, m2 = 0;
   string t0 = "R1", t1 = "R1", t2 = "R1";

   task automatic chk(input string tag, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // model of the next count of each variant
   function automatic int nx_free(int m, bit c, bit l, bit a, bit e, int val);
      if (c) return 0;
      if (l) return val;
      if (a && e) return (m + 1) % 256;
      return m;
   endfunction

   function automatic int nx_reload(int m, bit c, bit l, bit a, bit e, int val);
      if (c) return 0;
      if (l) return val % 16;
      if (e && m == 15) return 5;
      if (a && e) return (m + 1) % 16;
      return m;
   endfunction

   function automatic int nx_trunc(int m, bit c, bit l, bit a, bit e, int val);
      if (c || m == 10) return 0;
      if (l) return val % 16;
      if (a && e) return (m + 1) % 16;
      return m;
   endfunction

   task automatic apply(input bit c, input bit l, input bit a, input bit e, input logic [7:0] val);
      @(negedge clk);
      if (valid) begin
         chk(t0, "u0 count", int'(q0), m0);
         chk(t1, "u1 count", int'(q1), m1);
         chk(t2, "u2 count", int'(q2), m2);
      end
      clr = c; ld = l; ea = a; ec = e; v = val;
      #1;
      if (valid) begin
         chk("R4", "u0 carry", int'(c0), int'(e && m0 == 255));
         chk("R4", "u1 carry", int'(c1), int'(e && m1 == 15));
         chk("R4", "u2 carry", int'(c2), int'(e && m2 == 15));
      end
      @(posedge clk);
      t0 = c ? "R1" : l ? "R2" : (a && e && m0 == 255) ? "R5" :
           (a && e && (m0 % 16) == 15) ? "R6" : "R3";
      t1 = c ? "R1" : l ? "R2" : (e && m1 == 15) ? "R7" : "R3";
      t2 = c ? "R1" : (m2 == 10) ? "R8" : l ? "R2" : "R3";
      m0 = nx_free(m0, c, l, a, e, int'(val));
      m1 = nx_reload(m1, c, l, a, e, int'(val));
      m2 = nx_trunc(m2, c, l, a, e, int'(val));
      if (c) valid = 1'b1;
   endtask

   initial begin
      int unsigned sd;
      sd = $urandom(32'h0001_2e5d);
      // R1: clear beats load and enables
      apply(1, 1, 1, 1, 8'hAB);
      // R2: load with both enables high
      apply(0, 1, 1, 1, 8'h0F);
      // R6 on u0 (0x0F -> 0x10), R7 on u1 (15 -> 5)
      apply(0, 0, 1, 1, 8'h00);
      // R3: hold with one enable low
      apply(0, 0, 0, 1, 8'h33);
      apply(0, 0, 1, 0, 8'h44);
      // R4: carry at all ones with en_a low; then R5 wrap
      apply(0, 1, 0, 0, 8'hFF);
      apply(0, 0, 0, 1, 8'h00);
      apply(0, 0, 1, 1, 8'h00);
      // R8: load requested while u2 sits at 10
      apply(0, 1, 0, 0, 8'h0A);
      apply(0, 1, 1, 1, 8'h07);
      // R5/R7/R8: free run from clear
      apply(1, 0, 0, 0, 8'h00);
      for (int i = 0; i < 300; i++) apply(0, 0, 1, 1, 8'h00);
      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         apply(($urandom % 16) == 0, ($urandom % 8) == 0,
               ($urandom % 4) != 0, ($urandom % 4) != 0, 8'($urandom));
      end
      apply(0, 0, 0, 0, 8'h00);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         nfail++;
         $display("FAIL watchdog: got %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule